// File: doc/BRIEF.md
# Two-Level Microprogram Bus Sequencer

This block walks a stored instruction program made of two levels. The upper level is a list of micro-ops. Each one carries an internal action code and can point to a list of bus steps. A bus step pairs a memory microcycle descriptor with an action code that runs after the cycle. Both levels sit in small read-only tables inside the block. The block drives a request/acknowledge memory handshake and sends one-cycle action strobes, each with a code, to a datapath outside it. The datapath does the actual address arithmetic and the queue moves.

A program starts through a valid/ready handshake on its first micro-op index. While the block is busy, `start_ready` stays low and any offer on `start_valid` is left waiting without effect. On the memory side, `mem_req` is the valid of a request and `mem_ack` is its ready. The request and its descriptor stay held, without limit, until acknowledge. When a program finishes, the block asks for the next instruction only if no pending request is present. Otherwise it runs the fixed reset bus-step list first. Synchronous reset also starts that same list.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_req` and `start_ready` are low. After release, the block runs the fixed reset bus-step list at step index 0: a read from the PC (`mem_sel`=0) then action 5, a second PC read then action 6, then the end of the list.
- R2: In each cycle, at most one of `uop_stb`, `step_stb`, `mem_req` and `sched_next` is high. A micro-op's action strobe comes before the first bus cycle of its attached list.
- R3: A bus step's microcycle completes before its action. When `mem_ack` is sampled high with `mem_req`, `step_stb` is high in the next cycle. The action codes are: 1 EA0+2, 2 EA1+2, 3 EA0-2, 4 EA1-2, 5 PC+2, 6 prefetch advance (slot 1 to slot 0), 7 end of list.
- R4: Once raised, `mem_req` stays high and `mem_we`/`mem_sel` stay unchanged until `mem_ack`. Any number of wait cycles is accepted. `mem_sel` is coded 0 PC, 1 EA0, 2 EA1.
- R5: A bus step with action 7 performs no microcycle, even when one is encoded. It emits no strobe and passes control to the next micro-op.
- R6: A micro-op with no bus list ends the program, and its action code is still strobed on `uop_stb`.
- R7: A bus step whose cycle kind is "none" raises no request and strobes its action directly.
- R8: At program end, `sched_next` pulses for one cycle and the block becomes ready only if `pend_req` is low. If `pend_req` is high, the reset bus-step list runs instead, with no `sched_next` before it.
- R9: A program is accepted on a cycle with `start_valid` and `start_ready` both high. A `start_valid` offered while busy has no effect on the running program.
- R10: Micro-op action codes are strobed as stored (1..5 in the table). Program 0 at index 0 gives uop 1, bus list {read EA0 then 1, write EA1 then 4, no-cycle 2}, uop 2, bus list {read PC then 5}, uop 3. Program 1 at index 3 gives uop 4 with an empty list, then uop 1. Program 2 at index 5 is the single uop 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Offer of a program start |
| start_ready | output | 1 | Block idle and able to accept a start |
| start_idx | input | 3 | First micro-op index of the program |
| pend_req | input | 1 | Pending reset/exception request, sampled at program end |
| mem_req | output | 1 | Memory microcycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_sel | output | 2 | Address source: 0 PC, 1 EA0, 2 EA1 |
| mem_ack | input | 1 | Memory acknowledge; completes the request |
| uop_stb | output | 1 | Micro-op action pulse |
| uop_code | output | 3 | Micro-op action code |
| step_stb | output | 1 | Bus-step action pulse |
| step_code | output | 3 | Bus-step action code |
| sched_next | output | 1 | Next-instruction request pulse |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high. They also assume that `pend_req` is a level input that may change in any cycle. The stimulus raises acknowledge only in a cycle where it sees the request high, after a chosen number of wait cycles, and drops it at once afterwards. `pend_req` is cleared only while the reset bus-step list is running. Starts are offered with a fixed index during each program. One scenario also holds `start_valid` high while the block is busy, to check that it is ignored.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int STEP_AW = 4;
  localparam int UOP_AW  = 3;
  localparam int ACT_W   = 3;

  typedef enum logic [1:0] {CYC_NONE = 2'd0, CYC_RD = 2'd1, CYC_WR = 2'd2} cyc_e;

  typedef enum logic [ACT_W-1:0] {
    SA_NONE    = 3'd0,
    SA_EA0_INC = 3'd1,
    SA_EA1_INC = 3'd2,
    SA_EA0_DEC = 3'd3,
    SA_EA1_DEC = 3'd4,
    SA_PC_INC  = 3'd5,
    SA_PFQ_ADV = 3'd6,
    SA_END     = 3'd7
  } sact_e;

  typedef struct packed {
    cyc_e        cyc;
    logic [1:0]  sel;
    sact_e       act;
  } step_t;

  typedef struct packed {
    logic [ACT_W-1:0]   act;
    logic               has_list;
    logic [STEP_AW-1:0] list;
  } uop_t;

  typedef enum logic [2:0] {
    S_IDLE, S_UOP, S_STEP, S_BUS, S_ACT, S_END
  } st_e;
endpackage

// File: rtl/useq_step_rom.sv
module useq_step_rom
  import useq_pkg::*;
(
  input  logic [STEP_AW-1:0] idx,
  output step_t              ent
);
  always_comb begin
    case (idx)
      // reset list
      4'd0: ent = '{CYC_RD,   2'd0, SA_PC_INC};
      4'd1: ent = '{CYC_RD,   2'd0, SA_PFQ_ADV};
      4'd2: ent = '{CYC_RD,   2'd0, SA_END};
      // list A
      4'd3: ent = '{CYC_RD,   2'd1, SA_EA0_INC};
      4'd4: ent = '{CYC_WR,   2'd2, SA_EA1_DEC};
      4'd5: ent = '{CYC_NONE, 2'd0, SA_EA1_INC};
      4'd6: ent = '{CYC_WR,   2'd1, SA_END};
      // list B
      4'd7: ent = '{CYC_RD,   2'd0, SA_PC_INC};
      4'd8: ent = '{CYC_NONE, 2'd0, SA_END};
      // list C (empty)
      default: ent = '{CYC_NONE, 2'd0, SA_END};
    endcase
  end
endmodule

// File: rtl/useq_uop_rom.sv
module useq_uop_rom
  import useq_pkg::*;
(
  input  logic [UOP_AW-1:0] idx,
  output uop_t              ent
);
  always_comb begin
    case (idx)
      3'd0: ent = '{3'd1, 1'b1, 4'd3};
      3'd1: ent = '{3'd2, 1'b1, 4'd7};
      3'd2: ent = '{3'd3, 1'b0, 4'd0};
      3'd3: ent = '{3'd4, 1'b1, 4'd9};
      3'd4: ent = '{3'd1, 1'b0, 4'd0};
      3'd5: ent = '{3'd5, 1'b0, 4'd0};
      default: ent = '{3'd0, 1'b0, 4'd0};
    endcase
  end
endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
  import useq_pkg::*;
#(
  parameter logic [STEP_AW-1:0] RST_STEP = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [UOP_AW-1:0]   start_idx,
  input  logic                pend_req,
  output logic [UOP_AW-1:0]   uptr,
  output logic [STEP_AW-1:0]  sptr,
  input  uop_t                uop,
  input  step_t               step,
  output logic                mem_req,
  output logic                mem_we,
  output logic [1:0]          mem_sel,
  input  logic                mem_ack,
  output logic                uop_stb,
  output logic [ACT_W-1:0]    uop_code,
  output logic                step_stb,
  output logic [ACT_W-1:0]    step_code,
  output logic                sched_next
);
  st_e  state;
  logic in_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_STEP;
      sptr    <= RST_STEP;
      uptr    <= '0;
      in_prog <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          uptr    <= start_idx;
          in_prog <= 1'b1;
          state   <= S_UOP;
        end
        S_UOP: if (uop.has_list) begin
          sptr  <= uop.list;
          state <= S_STEP;
        end else begin
          state <= S_END;
        end
        S_STEP: if (step.act == SA_END) begin
          if (in_prog) begin
            uptr  <= uptr + 1'b1;
            state <= S_UOP;
          end else begin
            state <= S_END;
          end
        end else if (step.cyc != CYC_NONE) begin
          state <= S_BUS;
        end else begin
          state <= S_ACT;
        end
        S_BUS: if (mem_ack) state <= S_ACT;
        S_ACT: begin
          sptr  <= sptr + 1'b1;
          state <= S_STEP;
        end
        S_END: if (pend_req) begin
          sptr    <= RST_STEP;
          in_prog <= 1'b0;
          state   <= S_STEP;
        end else begin
          state <= S_IDLE;
        end
        default: state <= S_STEP;
      endcase
    end
  end

  always_comb begin
    start_ready = (state == S_IDLE);
    uop_stb     = (state == S_UOP) && (uop.act != '0);
    uop_code    = uop.act;
    step_stb    = (state == S_ACT) && (step.act != SA_NONE);
    step_code   = step.act;
    mem_req     = (state == S_BUS);
    mem_we      = (step.cyc == CYC_WR);
    mem_sel     = step.sel;
    sched_next  = (state == S_END) && !pend_req;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_sel));

  // R3
  act_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> step_stb);

  // R8
  sched_pend_chk: assert property (@(posedge clk) disable iff (rst)
    sched_next |-> !pend_req);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !mem_req && !start_ready);

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uop_stb, step_stb, mem_req, sched_next}));

  // R5
  end_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_STEP && step.act == SA_END |=> !mem_req);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [2:0]        start_idx,
  input  logic              pend_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  input  logic              mem_ack,
  output logic              uop_stb,
  output logic [2:0]        uop_code,
  output logic              step_stb,
  output logic [2:0]        step_code,
  output logic              sched_next
);
  logic [UOP_AW-1:0]  uptr;
  logic [STEP_AW-1:0] sptr;
  uop_t               uop;
  step_t              step;

  useq_uop_rom u_uop_rom (.idx(uptr), .ent(uop));
  useq_step_rom u_step_rom (.idx(sptr), .ent(step));

  useq_fsm #(.RST_STEP('0)) u_fsm (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_ready(start_ready), .start_idx(start_idx),
    .pend_req(pend_req),
    .uptr(uptr), .sptr(sptr), .uop(uop), .step(step),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_ack(mem_ack),
    .uop_stb(uop_stb), .uop_code(uop_code),
    .step_stb(step_stb), .step_code(step_code),
    .sched_next(sched_next)
  );
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_valid = 1'b0;
  logic [2:0] start_idx = '0;
  logic pend_req = 1'b0;
  logic mem_ack = 1'b0;
  logic start_ready, mem_req, mem_we, uop_stb, step_stb, sched_next;
  logic [1:0] mem_sel;
  logic [2:0] uop_code, step_code;

  always #4 clk = ~clk;

  useq_top uut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .start_idx(start_idx), .pend_req(pend_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_ack(mem_ack), .uop_stb(uop_stb), .uop_code(uop_code),
    .step_stb(step_stb), .step_code(step_code), .sched_next(sched_next)
  );

  int checks = 0;
  int errors = 0;
  int log_q [32];
  int log_n = 0;
  int exp_q [16];
  int done_cnt = 0;
  int waits = 0;
  int reqlen = 0;
  int cyc = 0;
  bit ack_q = 0;
  bit clr_pend_on_bus = 0;
  logic prev_we;
  logic [1:0] prev_sel;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and acknowledge responder
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ack_q) chk(step_stb === 1'b1, "R3 action after ack", step_stb, 1);
      chk($countones({uop_stb, step_stb, mem_req, sched_next}) <= 1, "R2 one event",
          $countones({uop_stb, step_stb, mem_req, sched_next}), 1);
      if (uop_stb && log_n < 32) begin log_q[log_n] = 300 + int'(uop_code); log_n++; end
      if (step_stb && log_n < 32) begin log_q[log_n] = 200 + int'(step_code); log_n++; end
      if (sched_next) begin
        chk(pend_req == 1'b0, "R8 sched with pend", pend_req, 0);
        if (log_n < 32) begin log_q[log_n] = 400; log_n++; end
        done_cnt++;
      end
      if (mem_req) begin
        if (clr_pend_on_bus) begin pend_req = 1'b0; clr_pend_on_bus = 0; end
        if (reqlen > 0)
          chk(mem_we === prev_we && mem_sel === prev_sel, "R4 stable descriptor",
              {mem_we, mem_sel}, {prev_we, prev_sel});
        prev_we = mem_we;
        prev_sel = mem_sel;
        reqlen++;
        if (reqlen > waits) begin
          mem_ack = 1'b1;
          if (log_n < 32) begin
            log_q[log_n] = 100 + 10 * int'(mem_we) + int'(mem_sel); log_n++;
          end
        end
      end else begin
        if (reqlen > 0 && !ack_q) chk(1'b0, "R4 request dropped before ack", 0, 1);
        mem_ack = 1'b0;
        reqlen = 0;
      end
      ack_q = mem_ack;
      if (ack_q) reqlen = 0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic compare(input int n, input string req);
    chk(log_n == n, req, log_n, n);
    for (int i = 0; i < n && i < log_n; i++)
      chk(log_q[i] == exp_q[i], req, log_q[i], exp_q[i]);
  endtask

  task automatic launch(input int idx, input int hold_busy);
    int d0;
    d0 = done_cnt;
    while (start_ready !== 1'b1) @(negedge clk);
    log_n = 0;
    start_valid = 1'b1;
    start_idx = 3'(idx);
    @(negedge clk);
    chk(start_ready == 1'b0, "R9 accepted", start_ready, 0);
    if (hold_busy > 0) begin
      start_idx = 3'd5;
      repeat (hold_busy) @(negedge clk);
    end
    start_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_prog0();
    exp_q[0] = 301; exp_q[1] = 101; exp_q[2] = 201; exp_q[3] = 112;
    exp_q[4] = 204; exp_q[5] = 202; exp_q[6] = 302; exp_q[7] = 100;
    exp_q[8] = 205; exp_q[9] = 303; exp_q[10] = 400;
  endtask

  // R1: reset state and reset bus-step list
  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0, "R1 req in reset", mem_req, 0);
    chk(start_ready == 1'b0, "R1 ready in reset", start_ready, 0);
    chk(sched_next == 1'b0, "R1 sched in reset", sched_next, 0);
    log_n = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(start_ready == 1'b0, "R1 busy after release", start_ready, 0);
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    exp_q[0] = 100; exp_q[1] = 205; exp_q[2] = 100; exp_q[3] = 206; exp_q[4] = 400;
    compare(5, "R1 R5 reset list");
    chk(start_ready == 1'b1, "R8 ready after end", start_ready, 1);
  endtask

  // R2 R3 R5 R6 R7 R10: full two-level program
  task automatic t_prog0();
    waits = 0;
    launch(0, 0);
    fill_prog0();
    compare(11, "R10 R2 R7 program 0");
  endtask

  // R4: wait states
  task automatic t_waits();
    waits = 3;
    launch(0, 0);
    fill_prog0();
    compare(11, "R4 program 0 with waits");
    waits = 0;
  endtask

  // R5 R6: empty list, terminal micro-op
  task automatic t_prog1();
    launch(3, 0);
    exp_q[0] = 304; exp_q[1] = 301; exp_q[2] = 400;
    compare(3, "R5 R6 program 1");
    launch(5, 0);
    exp_q[0] = 305; exp_q[1] = 400;
    compare(2, "R6 program 2");
  endtask

  // R8: pending request diverts to reset list
  task automatic t_pend();
    while (start_ready !== 1'b1) @(negedge clk);
    pend_req = 1'b1;
    clr_pend_on_bus = 1;
    launch(5, 0);
    exp_q[0] = 305; exp_q[1] = 100; exp_q[2] = 205; exp_q[3] = 100;
    exp_q[4] = 206; exp_q[5] = 400;
    compare(6, "R8 pending end");
  endtask

  // R9: start offered while busy is ignored
  task automatic t_busy_start();
    launch(0, 4);
    fill_prog0();
    compare(11, "R9 busy start ignored");
    repeat (3) @(negedge clk);
    chk(uop_stb == 1'b0 && start_ready == 1'b1, "R9 no extra program", uop_stb, 0);
  endtask

  initial begin
    t_reset();
    t_prog0();
    t_waits();
    t_prog1();
    t_pend();
    t_busy_start();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule